// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address for one port of a synchronous memory. At every rising clock edge it takes one of four actions, chosen by three active-low controls: it clears the address to zero, loads an address presented on an input bus, keeps the address it already has, or moves on to the next address. Its output is the registered address for the current access. A one-cycle flag marks each cycle in which that address came from the input bus and not from counting.

The controls have a fixed priority. A clear overrides everything else. A load overrides counting. Counting or holding applies only when neither of the other two is asked for. The block has no chip-select input. A burst start address can therefore be loaded and stepped while the memory port itself is deselected. The address width is a parameter with a default of 17 bits, which covers 128K locations. Counting past the highest address wraps back to zero.

An asynchronous active-low reset clears the block at once. Its release is synchronised to the clock, so the controls take effect only after a fixed number of edges.

Top module: `burst_addr_gen`

## Requirements
- R1: When `clear_n` is 0 at a rising edge, `addr` is 0 after that edge, whatever `strobe_n`, `step_n` and `ext_addr` are.
- R2: When `clear_n` is 1 and `strobe_n` is 0 at a rising edge, `addr` takes the value of `ext_addr` sampled at that edge, and `step_n` has no effect.
- R3: When `clear_n`, `strobe_n` and `step_n` are all 1 at a rising edge, `addr` keeps its value and changes on `ext_addr` have no effect.
- R4: When `clear_n` and `strobe_n` are 1 and `step_n` is 0 at a rising edge, `addr` becomes its previous value plus one.
- R5: A step taken from the all-ones address (0x1FFFF at the default width) gives address 0.
- R6: `loaded` is 1 for exactly the cycle after an edge that performed a load (R2). It is 0 after any other edge, including a clear made while `strobe_n` is 0.
- R7: While `rst_n` is 0, `addr` and `loaded` are 0, starting immediately rather than at the next edge. After `rst_n` rises, the first SYNC_STAGES rising edges (2 by default) leave both at 0 whatever the controls are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear_n | input | 1 | Active-low synchronous clear of the address (highest priority) |
| strobe_n | input | 1 | Active-low load strobe for `ext_addr` |
| step_n | input | 1 | Active-low count enable (lowest priority) |
| ext_addr | input | AW | Externally supplied address |
| addr | output | AW | Registered address for the current access |
| loaded | output | 1 | High for the cycle after a load |

## Verification
Each of `addr` and `loaded` passes through exactly one register. A control pattern present at a rising edge therefore shows its result in the cycle that begins at that edge. The bench changes inputs on the falling edge and compares outputs on the next falling edge, half a period after the single edge that acts on them. The reset window is checked in a different way. Outputs are sampled one time step after `rst_n` falls, which confirms the immediate clear. After release, they are sampled after each of the two edges that must still be ignored.

// File: rtl/bac_pkg.sv
package bac_pkg;

  // Action applied to the address register on the coming clock edge.
  typedef enum logic [1:0] {
    BAC_CLEAR = 2'd0,
    BAC_LOAD  = 2'd1,
    BAC_HOLD  = 2'd2,
    BAC_STEP  = 2'd3
  } bac_op_e;

endpackage

// File: rtl/bac_rst_sync.sv
module bac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/bac_op_decode.sv
module bac_op_decode
  import bac_pkg::*;
(
  input  logic    clear_n,
  input  logic    strobe_n,
  input  logic    step_n,
  output bac_op_e op
);

  // Fixed priority: clear, then load, then step or hold.
  always_comb begin
    if (!clear_n)       op = BAC_CLEAR;
    else if (!strobe_n) op = BAC_LOAD;
    else if (!step_n)   op = BAC_STEP;
    else                op = BAC_HOLD;
  end

endmodule

// File: rtl/bac_addr_reg.sv
module bac_addr_reg
  import bac_pkg::*;
#(
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bac_op_e       op,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr_q,
  output logic          loaded_q
);

  localparam logic [AW-1:0] ADDR_ZERO = '0;
  localparam logic [AW-1:0] ADDR_ONE  = AW'(1);

  logic [AW-1:0] addr_d;
  logic          addr_en;
  logic          loaded_d;

  // Next-state logic
  always_comb begin
    addr_d   = addr_q;
    loaded_d = 1'b0;
    unique case (op)
      BAC_CLEAR: addr_d = ADDR_ZERO;
      BAC_LOAD: begin
        addr_d   = ext_addr;
        loaded_d = 1'b1;
      end
      BAC_STEP:  addr_d = addr_q + ADDR_ONE;  // natural wrap at all-ones
      default:   addr_d = addr_q;
    endcase
  end

  assign addr_en = (op != BAC_HOLD);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= ADDR_ZERO;
      loaded_q <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      loaded_q <= loaded_d;
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
#(
  parameter int unsigned AW          = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_n,
  input  logic          strobe_n,
  input  logic          step_n,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr,
  output logic          loaded
);

  logic    core_rst_n;
  bac_op_e op;

  bac_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  bac_op_decode u_decode (
    .clear_n  (clear_n),
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .op       (op)
  );

  bac_addr_reg #(
    .AW (AW)
  ) u_addr_reg (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .op       (op),
    .ext_addr (ext_addr),
    .addr_q   (addr),
    .loaded_q (loaded)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_rst_n,
  input logic          clear_n,
  input logic          strobe_n,
  input logic          step_n,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] addr,
  input logic          loaded
);

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    !clear_n |=> (addr == '0));

  p_load_ext_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clear_n && !strobe_n) |=> (addr == $past(ext_addr)));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clear_n && strobe_n && step_n) |=> $stable(addr));

  p_step_inc_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clear_n && strobe_n && !step_n) |=> (addr == AW'($past(addr) + 1'b1)));

  p_step_wrap_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clear_n && strobe_n && !step_n && (&addr)) |=> (addr == '0));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clear_n && !strobe_n) |=> loaded);

  p_flag_clr_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(clear_n && !strobe_n) |=> !loaded);

  p_reset_zero_r7: assert property (@(posedge clk)
    (!rst_n || !core_rst_n) |-> (addr == '0 && !loaded));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int unsigned AW = 17;
  localparam time         TCK = 20ns;
  localparam logic [AW-1:0] ALL_ONES = '1;

  logic          clk;
  logic          rst_n;
  logic          clear_n;
  logic          strobe_n;
  logic          step_n;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] addr;
  logic          loaded;

  int n_cmp;
  int n_bad;
  logic [AW-1:0] exp_addr;

  burst_addr_gen #(.AW(AW), .SYNC_STAGES(2)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_n  (clear_n),
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .ext_addr (ext_addr),
    .addr     (addr),
    .loaded   (loaded)
  );

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drive one control pattern at the falling edge, let one rising edge act,
  // then compare at the next falling edge against the requirement model.
  task automatic cyc(input logic c, input logic s, input logic t,
                     input logic [AW-1:0] e);
    string         tag;
    logic          exp_ld;
    clear_n  = c;
    strobe_n = s;
    step_n   = t;
    ext_addr = e;
    exp_ld   = 1'b0;
    if (!c) begin
      exp_addr = '0;                     tag = "R1";
    end else if (!s) begin
      exp_addr = e; exp_ld = 1'b1;       tag = "R2";
    end else if (!t) begin
      tag = (exp_addr == ALL_ONES) ? "R5" : "R4";
      exp_addr = exp_addr + 1'b1;
    end else begin
      tag = "R3";
    end
    @(negedge clk);
    chk(tag, "addr", 32'(addr), 32'(exp_addr));
    chk("R6", "loaded", 32'(loaded), 32'(exp_ld));
  endtask

  task automatic test_power_on();  // R7
    rst_n = 1'b0; clear_n = 1'b1; strobe_n = 1'b1; step_n = 1'b1;
    ext_addr = '0;
    repeat (3) @(negedge clk);
    chk("R7", "addr in reset", 32'(addr), 0);
    chk("R7", "loaded in reset", 32'(loaded), 0);
    rst_n = 1'b1;
    strobe_n = 1'b0; step_n = 1'b0; ext_addr = 17'h00155;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R7", "addr in release window", 32'(addr), 0);
      chk("R7", "loaded in release window", 32'(loaded), 0);
    end
    exp_addr = '0;
  endtask

  task automatic test_load_ignores_step();  // R2 R6
    cyc(1'b1, 1'b0, 1'b0, 17'h0ABCD);
    cyc(1'b1, 1'b0, 1'b1, 17'h13579);
  endtask

  task automatic test_hold();  // R3
    cyc(1'b1, 1'b1, 1'b1, 17'h00FFF);
    cyc(1'b1, 1'b1, 1'b1, 17'h1AAAA);
    cyc(1'b1, 1'b1, 1'b1, 17'h00000);
  endtask

  task automatic test_step();  // R4
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b0, 17'h0F0F0);
    cyc(1'b1, 1'b1, 1'b1, 17'h0F0F0);
    cyc(1'b1, 1'b1, 1'b0, 17'h0F0F0);
  endtask

  task automatic test_wrap();  // R5
    cyc(1'b1, 1'b0, 1'b1, 17'h1FFFE);
    cyc(1'b1, 1'b1, 1'b0, 17'h00000);
    cyc(1'b1, 1'b1, 1'b0, 17'h00000);
    cyc(1'b1, 1'b1, 1'b0, 17'h00000);
  endtask

  task automatic test_clear_priority();  // R1 R6
    cyc(1'b1, 1'b0, 1'b1, 17'h12345);
    cyc(1'b0, 1'b0, 1'b0, 17'h1FFFF);
    cyc(1'b1, 1'b1, 1'b0, 17'h1FFFF);
    cyc(1'b0, 1'b1, 1'b1, 17'h00000);
  endtask

  task automatic test_reload_mid_burst();  // R2 R4 R6
    cyc(1'b1, 1'b0, 1'b1, 17'h00100);
    cyc(1'b1, 1'b1, 1'b0, 17'h00100);
    cyc(1'b1, 1'b1, 1'b0, 17'h00100);
    cyc(1'b1, 1'b0, 1'b0, 17'h00800);
    cyc(1'b1, 1'b1, 1'b0, 17'h00800);
  endtask

  task automatic test_async_reset();  // R7
    cyc(1'b1, 1'b0, 1'b1, 17'h0C0DE);
    clear_n = 1'b1; strobe_n = 1'b0; step_n = 1'b0; ext_addr = 17'h01111;
    #(TCK/4);
    rst_n = 1'b0;
    #1;
    chk("R7", "addr right after async reset", 32'(addr), 0);
    chk("R7", "loaded right after async reset", 32'(loaded), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R7", "addr in release window", 32'(addr), 0);
    end
    exp_addr = '0;
    cyc(1'b1, 1'b1, 1'b0, 17'h00000);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    exp_addr = '0;
    test_power_on();
    test_load_ignores_step();
    test_hold();
    test_step();
    test_wrap();
    test_clear_priority();
    test_reload_mid_burst();
    test_async_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(TCK * 5000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule